// File: doc/BRIEF.md
# Dual-Clock FIFO with Reset-Strapped Write Qualifier

This block is a nine-bit-wide first-in first-out buffer. Its write side and its read side each run on their own clock. The depth is a power-of-two parameter. A write needs two enables: an active-low primary enable and a dual-purpose pin. A read needs two active-low read enables. The read word appears on a registered data output. A separate drive-enable output tells the pad logic when that output may be driven.

The dual-purpose pin is sampled while reset is held, and its level fixes the operating mode until the next reset:

- High selects two-enable mode, where the pin is a second, active-high write enable.
- Low selects programmable-flag mode, where the pin is a load strobe. A FIFO write then needs the strobe high.

The chosen mode is exported so that a neighbouring almost-flag generator knows how to treat the pin. The buffer also exports its fill level, measured from the write side and from the read side, for that generator to compare against its offsets.

Both flags are registered and active-low. Empty is computed on the read side and full on the write side, from pointers that cross the clock domains as Gray code through two-flop synchronizers. Writes attempted when full and reads attempted when empty are dropped. When a read is dropped, the output keeps the last word that was read successfully.

Top module: `dual_clock_fifo`

## Requirements
- R1: While reset is held, empty_n is 0, full_n is 1, dout is all zeros and both fill outputs are 0.
- R2: prog_mode after reset equals the inverse of the wen2_ld level held during reset (wen2_ld=1 gives prog_mode=0, two-enable mode; wen2_ld=0 gives prog_mode=1, programmable-flag mode).
- R3: In two-enable mode a word is stored on a wr_clk rising edge only when wen1_n=0, wen2_ld=1 and full_n=1; with wen2_ld=0 nothing is stored.
- R4: In programmable-flag mode wen1_n=0 with the load strobe wen2_ld=1 stores a word; with wen2_ld=0 the FIFO contents are unchanged.
- R5: A read happens on a rd_clk rising edge only when ren1_n=0, ren2_n=0 and empty_n=1; with either enable high, dout and the fill level stay unchanged.
- R6: Words leave in the order they were stored, and dout takes the next word on the rd_clk edge that accepts the read.
- R7: A write attempted while full_n=0 is dropped: the fill level stays at DEPTH and the word never appears at dout.
- R8: A read attempted while empty_n=0 is dropped and dout keeps the last word read.
- R9: dout_oe equals the inverse of oe_n as sampled on the previous rd_clk edge (1 = drive dout).
- R10: Once both clocks have run at least five edges with no traffic, wr_fill and rd_fill both equal the number of stored words and never exceed DEPTH.
- R11: empty_n becomes 1 within four rd_clk edges of the first write, and full_n becomes 0 on the wr_clk edge that stores the DEPTH-th word.
- R12: Write and read enables applied while reset is held store and remove nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Active-high reset, synchronized into each domain |
| din | input | 9 | Write data |
| wen1_n | input | 1 | Primary write enable, active low |
| wen2_ld | input | 1 | Second write enable or load strobe; its level during reset selects the mode |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 9 | Registered read data |
| dout_oe | output | 1 | Registered drive enable for dout |
| empty_n | output | 1 | Empty flag, low when empty |
| full_n | output | 1 | Full flag, low when full |
| prog_mode | output | 1 | 1 when programmable-flag mode was strapped |
| wr_fill | output | log2(DEPTH)+1 | Fill level seen on the write side |
| rd_fill | output | log2(DEPTH)+1 | Fill level seen on the read side |

## Verification
The timing of each result is different:

- dout and dout_oe change on the same rd_clk edge that accepts the read or samples oe_n. The bench reads them one nanosecond after that edge.
- full_n falls on the wr_clk edge that stores the last free word.
- A result that crosses domains reaches the other side only after the two synchronizer flops plus one flag register, about three edges of the receiving clock. This covers empty_n rising and both fill values.

The bench therefore checks a cross-domain result only after a settle period of six edges on each clock. It decides whether an access is accepted from the flag level seen at the falling edge before the access, because the flags cannot change until the next rising edge.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DATA_W = 9;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk,
  input  logic rst_in,
  output logic rst_out
);
  logic [1:0] stage;

  always_ff @(posedge clk or posedge rst_in)
    if (rst_in) stage <= 2'b11;
    else        stage <= {stage[0], 1'b0};

  assign rst_out = stage[1] | rst_in;
endmodule

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk)
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int AW = 4
) (
  input  logic                 wclk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  dcf_pkg::word_t       wdata,
  input  logic                 rclk,
  input  logic                 rrst,
  input  logic                 re,
  input  logic [AW-1:0]        raddr,
  output dcf_pkg::word_t       rdata
);
  localparam int DEPTH = 1 << AW;
  dcf_pkg::word_t store [DEPTH];

  always_ff @(posedge wclk)
    if (we) store[waddr] <= wdata;

  always_ff @(posedge rclk)
    if (rrst)    rdata <= '0;
    else if (re) rdata <= store[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic [AW:0]   rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full_n,
  output logic [AW:0]   fill,
  output logic          prog_mode
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] wbin, wbin_nx, wgray_nx, rbin_s;
  logic        full_q, two_we;

  assign we       = !rst && !wen1_n && wen2_ld && !full_q;
  assign wbin_nx  = wbin + (AW+1)'(we);
  assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);
  assign rbin_s   = g2b(rgray_s);

  always_ff @(posedge clk)
    if (rst) begin
      wbin   <= '0;
      wgray  <= '0;
      full_q <= 1'b0;
      fill   <= '0;
      two_we <= wen2_ld;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wgray_nx;
      full_q <= (wgray_nx == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
      fill   <= wbin_nx - rbin_s;
    end

  assign full_n    = !full_q;
  assign waddr     = wbin[AW-1:0];
  assign prog_mode = !two_we;

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    full_q |=> (wbin == $past(wbin)));
  p_fill_bound_r10: assert property (@(posedge clk) disable iff (rst)
    fill <= (AW+1)'(DEPTH));
  p_gray_step_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic [AW:0]   wgray_s,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          empty_n,
  output logic [AW:0]   fill
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] rbin, rbin_nx, rgray_nx, wbin_s;
  logic        empty_q;

  assign re       = !rst && !ren1_n && !ren2_n && !empty_q;
  assign rbin_nx  = rbin + (AW+1)'(re);
  assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);
  assign wbin_s   = g2b(wgray_s);

  always_ff @(posedge clk)
    if (rst) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_q <= 1'b1;
      fill    <= '0;
    end else begin
      rbin    <= rbin_nx;
      rgray   <= rgray_nx;
      empty_q <= (rgray_nx == wgray_s);
      fill    <= wbin_s - rbin_nx;
    end

  assign empty_n = !empty_q;
  assign raddr   = rbin[AW-1:0];

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    empty_q |=> (rbin == $past(rbin)));
  p_rfill_bound_r10: assert property (@(posedge clk) disable iff (rst)
    fill <= (AW+1)'(DEPTH));
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = dcf_pkg::DATA_W
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          empty_n,
  output logic          full_n,
  output logic          prog_mode,
  output logic [AW:0]   wr_fill,
  output logic [AW:0]   rd_fill
);
  logic          rst_w, rst_r, we, re;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;

  dcf_rst_sync u_rst_w (.clk(wr_clk), .rst_in(rst), .rst_out(rst_w));
  dcf_rst_sync u_rst_r (.clk(rd_clk), .rst_in(rst), .rst_out(rst_r));

  dcf_sync2 #(.W(AW+1)) u_r2w (.clk(wr_clk), .rst(rst_w), .d(rgray), .q(rgray_s));
  dcf_sync2 #(.W(AW+1)) u_w2r (.clk(rd_clk), .rst(rst_r), .d(wgray), .q(wgray_s));

  dcf_wr_ctrl #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst(rst_w), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
    .full_n(full_n), .fill(wr_fill), .prog_mode(prog_mode));

  dcf_rd_ctrl #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst(rst_r), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .wgray_s(wgray_s), .re(re), .raddr(raddr), .rgray(rgray),
    .empty_n(empty_n), .fill(rd_fill));

  dcf_ram #(.AW(AW)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(din),
    .rclk(rd_clk), .rrst(rst_r), .re(re), .raddr(raddr), .rdata(dout));

  always_ff @(posedge rd_clk)
    if (rst_r) dout_oe <= 1'b0;
    else       dout_oe <= !oe_n;

  p_dout_hold_r8: assert property (@(posedge rd_clk) disable iff (rst_r)
    !empty_n |=> $stable(dout));
  p_oe_follow_r9: assert property (@(posedge rd_clk) disable iff (rst_r)
    1'b1 |=> (dout_oe == !$past(oe_n)));
  p_reset_flags_r1: assert property (@(posedge rd_clk)
    rst_r |=> (!empty_n && dout == '0));
endmodule

// File: tb/dual_clock_fifo_test.sv
module dual_clock_fifo_test;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic wr_clk = 0, rd_clk = 0, rst = 1;
  logic [8:0] din = '0;
  logic wen1_n = 1, wen2_ld = 1, ren1_n = 1, ren2_n = 1, oe_n = 1;
  logic [8:0] dout;
  logic dout_oe, empty_n, full_n, prog_mode;
  logic [AW:0] wr_fill, rd_fill;

  int n_checks = 0, n_fail = 0;
  logic [8:0] q[$];
  logic [8:0] last_word = '0;

  always #5 wr_clk = ~wr_clk;
  always #7 rd_clk = ~rd_clk;

  dual_clock_fifo #(.DEPTH(DEPTH)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .din(din),
    .wen1_n(wen1_n), .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .oe_n(oe_n), .dout(dout), .dout_oe(dout_oe), .empty_n(empty_n),
    .full_n(full_n), .prog_mode(prog_mode), .wr_fill(wr_fill), .rd_fill(rd_fill));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge wr_clk);
    repeat (6) @(posedge rd_clk);
    #1;
  endtask

  // Accepting a write is predicted from full_n seen at the falling edge
  task automatic wr(input logic [8:0] d, input logic w1, input logic w2);
    bit acc;
    @(negedge wr_clk);
    din = d; wen1_n = w1; wen2_ld = w2;
    acc = !w1 && w2 && full_n;
    @(posedge wr_clk);
    if (acc) q.push_back(d);
    @(negedge wr_clk);
    wen1_n = 1; wen2_ld = 1;
  endtask

  task automatic rd(input logic r1, input logic r2, input string req);
    bit acc;
    logic [8:0] exp;
    @(negedge rd_clk);
    ren1_n = r1; ren2_n = r2;
    acc = !r1 && !r2 && empty_n;
    @(posedge rd_clk);
    #1;
    if (acc) begin
      if (q.size() == 0) begin
        chk(0, "R8", 1, 0);
        exp = last_word;
      end else begin
        exp = q.pop_front();
      end
      last_word = exp;
    end else exp = last_word;
    chk(dout == exp, req, dout, exp);
    @(negedge rd_clk);
    ren1_n = 1; ren2_n = 1;
  endtask

  task automatic rst_dut(input logic pin);
    @(negedge wr_clk);
    rst = 1; wen2_ld = pin; wen1_n = 0; ren1_n = 0; ren2_n = 0; din = 9'h1AA;
    repeat (8) @(posedge rd_clk);
    #1;
    chk(empty_n == 0, "R1", empty_n, 0);
    chk(full_n == 1, "R1", full_n, 1);
    chk(dout == 0, "R1", dout, 0);
    chk(wr_fill == 0 && rd_fill == 0, "R1", rd_fill, 0);
    @(negedge wr_clk);
    wen1_n = 1; ren1_n = 1; ren2_n = 1;
    @(negedge wr_clk);
    rst = 0;
    repeat (5) @(negedge wr_clk);
    wen2_ld = 1;
    q.delete();
    last_word = '0;
    settle();
    chk(rd_fill == 0 && empty_n == 0, "R12", rd_fill, 0);
  endtask

  task automatic random_phase(input int n);
    fork
      begin
        for (int i = 0; i < n; i++)
          wr(9'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) != 0));
      end
      begin
        for (int i = 0; i < n; i++)
          rd(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0), "R6");
      end
    join
    settle();
    chk(wr_fill == (AW+1)'(q.size()), "R10", wr_fill, q.size());
    chk(rd_fill == (AW+1)'(q.size()), "R10", rd_fill, q.size());
    for (int i = 0; i < 4 * DEPTH && q.size() > 0; i++) rd(0, 0, "R6");
    settle();
    chk(q.size() == 0 && empty_n == 0, "R8", empty_n, 0);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    // two-enable mode
    rst_dut(1'b1);
    chk(prog_mode == 0, "R2", prog_mode, 0);

    wr(9'h055, 0, 0);
    settle();
    chk(rd_fill == 0 && empty_n == 0, "R3", rd_fill, 0);

    wr(9'h0A5, 0, 1);
    repeat (4) @(posedge rd_clk);
    #1;
    chk(empty_n == 1, "R11", empty_n, 1);
    settle();
    chk(wr_fill == 1 && rd_fill == 1, "R10", rd_fill, 1);

    rd(0, 1, "R5");
    rd(1, 0, "R5");
    settle();
    chk(rd_fill == 1, "R5", rd_fill, 1);
    rd(0, 0, "R6");
    rd(0, 0, "R8");

    @(negedge rd_clk); oe_n = 0;
    @(posedge rd_clk); #1;
    chk(dout_oe == 1, "R9", dout_oe, 1);
    @(negedge rd_clk); oe_n = 1;
    @(posedge rd_clk); #1;
    chk(dout_oe == 0, "R9", dout_oe, 0);

    settle();
    for (int i = 0; i < DEPTH; i++) wr(9'(9'h100 + i), 0, 1);
    chk(full_n == 0, "R11", full_n, 0);
    wr(9'h1FF, 0, 1);
    settle();
    chk(wr_fill == DEPTH, "R7", wr_fill, DEPTH);
    chk(rd_fill == DEPTH, "R10", rd_fill, DEPTH);
    for (int i = 0; i < DEPTH; i++) rd(0, 0, "R7");
    rd(0, 0, "R8");
    settle();
    chk(empty_n == 0 && rd_fill == 0, "R7", rd_fill, 0);

    random_phase(300);

    // programmable-flag mode
    rst_dut(1'b0);
    chk(prog_mode == 1, "R2", prog_mode, 1);
    wr(9'h033, 0, 0);
    settle();
    chk(rd_fill == 0, "R4", rd_fill, 0);
    wr(9'h077, 0, 1);
    settle();
    chk(rd_fill == 1, "R4", rd_fill, 1);
    rd(0, 0, "R4");

    random_phase(200);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule